// File: doc/BRIEF.md
# Double-Buffered Transmit Bit Serializer

The block turns host bytes into a serial bit stream at a programmable rate. It holds two 8-bit transmit registers chained one behind the other, plus a bit-rate tick generator that runs from the reference clock. While transmission is off, each host write pushes a byte into the chain, so a packet can be staged before sending begins. Both registers reset to 0xAA, so an unwritten register goes out as an alternating preamble.

Once transmission is on, the first register goes out MSB first. The second register follows, and after that the two take turns. Each time a register has been sent, the host gets a ready interrupt and refills that register while the other one is on the line. A sticky error flag records two host mistakes: a refill that came too late, and a write that replaced data not yet sent. The block drives one serial data bit and a strobe that marks the start of each bit. A host-side status line shows the ready state while the host is selected.

Top module: `txbit_serializer`

## Requirements
- R1: After reset both registers hold 0xAA, and txBit, bitStrobe, readyIrq, errFlag and sdoReady are all 0. Enabling with no writes sends 0xAA twice.
- R2: While txEnable is low, a write moves the second register's byte into the first register and loads the written byte into the second. After two writes, the first byte written is in the first register.
- R3: When txEnable rises, the first register is sent MSB first, then the second, and the two alternate after that. txBit is 0 whenever no transmission is running.
- R4: Every bit lasts 29 × (rateDiv + 1) × (rateX8 ? 8 : 1) clock cycles.
- R5: bitStrobe is high for exactly one clock, in the first cycle of each bit.
- R6: readyIrq is set when a register has been fully sent, and a write clears it. readyIrq stays low while transmission is off.
- R7: If a register finishes while the other register has not been refilled, errFlag is set. The other register's old contents are then sent again unchanged.
- R8: While transmitting, a write to a waiting register that already holds unsent data sets errFlag. The new byte replaces the old one and is the byte that gets sent.
- R9: errFlag stays set until a cycle with statusRead high clears it.
- R10: Dropping txEnable resets both registers to 0xAA.
- R11: sdoReady equals readyIrq while hostSelect is high, and is 0 while hostSelect is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous reset, active low |
| txEnable | input | 1 | Transmission on when high; falling edge reinitialises the registers |
| rateDiv | input | 7 | Bit-rate divider field R |
| rateX8 | input | 1 | Multiplies the bit period by 8 |
| wrValid | input | 1 | One-cycle host byte write |
| wrData | input | 8 | Byte written by the host |
| statusRead | input | 1 | Status read strobe, clears errFlag |
| hostSelect | input | 1 | Host select; gates sdoReady |
| txBit | output | 1 | Serial data bit |
| bitStrobe | output | 1 | One-cycle pulse at the start of each bit |
| readyIrq | output | 1 | A register is free for the next byte |
| errFlag | output | 1 | Sticky underrun/overwrite flag |
| sdoReady | output | 1 | Ready state shown while selected |

## Verification
The embedded properties check the following on every cycle: the strobe is a single-cycle pulse, the tick counter stays within the programmed period, and the interrupt rises at each register completion and falls on a refill. They also check that the error flag is set on an underrun or an overwrite and holds until a status read, and that disabling leaves both registers at 0xAA. Some behaviours only the scenarios can show. These are the exact bit order across alternating and stale registers, the shift order of the initial fill, the period length for several rate and prescale settings, and which byte goes out after an overwrite. The bench's scoreboard covers these by comparing each strobed bit against the expected stream.

// File: rtl/txs_pkg.sv
package txs_pkg;
  localparam int DATA_W = 8;
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [DATA_W-1:0] PREAMBLE = 8'hAA;

  // control-to-datapath strobes
  typedef struct packed {
    logic             sending;
    logic             shiftIn;
    logic             refill;
    logic             reinit;
    logic             sendSel;
    logic [IDX_W-1:0] bitIdx;
  } dpCtrl_t;
endpackage

// File: rtl/txs_rategen.sv
module txs_rategen #(
  parameter int RATE_W   = 7,
  parameter int BASE_DIV = 29,
  parameter int PRESCALE = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              run,
  input  logic [RATE_W-1:0] rateDiv,
  input  logic              rateX8,
  output logic              bitStart,
  output logic              bitEnd
);
  localparam int MAX_PERIOD = BASE_DIV * (1 << RATE_W) * PRESCALE;
  localparam int CNT_W = $clog2(MAX_PERIOD);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lastCnt;

  always_comb begin
    lastCnt = CNT_W'(32'(BASE_DIV) * (32'(rateDiv) + 32'd1)
                     * (rateX8 ? 32'(PRESCALE) : 32'd1) - 32'd1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (!run) begin
      cnt <= '0;
    end else if (cnt == lastCnt) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  assign bitStart = run && (cnt == '0);
  assign bitEnd   = run && (cnt == lastCnt);

  // R4
  count_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    run |-> cnt <= lastCnt);

  // R5
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitStart |=> !bitStart);
endmodule

// File: rtl/txs_ctrl.sv
module txs_ctrl
  import txs_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    txEnable,
  input  logic    wrValid,
  input  logic    statusRead,
  input  logic    bitEnd,
  output dpCtrl_t dpc,
  output logic    runNow,
  output logic    readyIrq,
  output logic    errFlag
);
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(DATA_W - 1);

  logic             sending;
  logic             sendSel;
  logic [IDX_W-1:0] bitIdx;
  logic             standbyFull;
  logic             byteDone;
  logic             refill;
  logic             underrun;
  logic             overwrite;

  assign runNow    = sending && txEnable;
  assign byteDone  = runNow && bitEnd && (bitIdx == '0);
  assign refill    = runNow && wrValid;
  assign underrun  = byteDone && !standbyFull && !wrValid;
  assign overwrite = refill && standbyFull;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sending     <= 1'b0;
      sendSel     <= 1'b0;
      bitIdx      <= TOP_IDX;
      standbyFull <= 1'b0;
      readyIrq    <= 1'b0;
    end else begin
      sending <= txEnable;
      if (!sending) begin
        sendSel     <= 1'b0;
        bitIdx      <= TOP_IDX;
        standbyFull <= 1'b1;
        readyIrq    <= 1'b0;
      end else if (!txEnable) begin
        readyIrq <= 1'b0;
      end else if (byteDone) begin
        sendSel     <= ~sendSel;
        bitIdx      <= TOP_IDX;
        standbyFull <= 1'b0;
        readyIrq    <= 1'b1;
      end else begin
        if (bitEnd) bitIdx <= bitIdx - IDX_W'(1);
        if (refill) begin
          standbyFull <= 1'b1;
          readyIrq    <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errFlag <= 1'b0;
    end else if (underrun || overwrite) begin
      errFlag <= 1'b1;
    end else if (statusRead) begin
      errFlag <= 1'b0;
    end
  end

  always_comb begin
    dpc.sending = runNow;
    dpc.shiftIn = !sending && wrValid;
    dpc.refill  = refill;
    dpc.reinit  = sending && !txEnable;
    dpc.sendSel = sendSel;
    dpc.bitIdx  = bitIdx;
  end

  // R6
  ready_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    byteDone |=> readyIrq);

  // R6
  ready_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (refill && !byteDone) |=> !readyIrq);

  // R7
  underrun_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    underrun |=> errFlag);

  // R8
  overwrite_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    overwrite |=> errFlag);

  // R9
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !statusRead) |=> errFlag);
endmodule

// File: rtl/txs_datapath.sv
module txs_datapath
  import txs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           dpc,
  input  logic [DATA_W-1:0] wrData,
  output logic              txBit
);
  localparam int SLOTS = 2;

  logic [DATA_W-1:0] slotReg [SLOTS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SLOTS; i++) slotReg[i] <= PREAMBLE;
    end else if (dpc.reinit) begin
      for (int i = 0; i < SLOTS; i++) slotReg[i] <= PREAMBLE;
    end else if (dpc.shiftIn) begin
      for (int i = 0; i < SLOTS - 1; i++) slotReg[i] <= slotReg[i+1];
      slotReg[SLOTS-1] <= wrData;
    end else if (dpc.refill) begin
      slotReg[~dpc.sendSel] <= wrData;
    end
  end

  assign txBit = dpc.sending & slotReg[dpc.sendSel][dpc.bitIdx];

  // R10
  reinit_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    dpc.reinit |=> (slotReg[0] == PREAMBLE) && (slotReg[1] == PREAMBLE));
endmodule

// File: rtl/txbit_serializer.sv
module txbit_serializer
  import txs_pkg::*;
#(
  parameter int RATE_W   = 7,
  parameter int BASE_DIV = 29,
  parameter int PRESCALE = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txEnable,
  input  logic [RATE_W-1:0] rateDiv,
  input  logic              rateX8,
  input  logic              wrValid,
  input  logic [DATA_W-1:0] wrData,
  input  logic              statusRead,
  input  logic              hostSelect,
  output logic              txBit,
  output logic              bitStrobe,
  output logic              readyIrq,
  output logic              errFlag,
  output logic              sdoReady
);
  dpCtrl_t dpc;
  logic    runNow;
  logic    bitEnd;

  txs_rategen #(
    .RATE_W  (RATE_W),
    .BASE_DIV(BASE_DIV),
    .PRESCALE(PRESCALE)
  ) uRate (
    .clk     (clk),
    .rstN    (rstN),
    .run     (runNow),
    .rateDiv (rateDiv),
    .rateX8  (rateX8),
    .bitStart(bitStrobe),
    .bitEnd  (bitEnd)
  );

  txs_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .txEnable  (txEnable),
    .wrValid   (wrValid),
    .statusRead(statusRead),
    .bitEnd    (bitEnd),
    .dpc       (dpc),
    .runNow    (runNow),
    .readyIrq  (readyIrq),
    .errFlag   (errFlag)
  );

  txs_datapath uData (
    .clk   (clk),
    .rstN  (rstN),
    .dpc   (dpc),
    .wrData(wrData),
    .txBit (txBit)
  );

  assign sdoReady = hostSelect & readyIrq;

  // R3
  idle_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !runNow |-> !txBit && !bitStrobe);
endmodule

// File: tb/sim_txbit_serializer.sv
`timescale 1ns/1ps
module sim_txbit_serializer;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       txEnable = 1'b0;
  logic [6:0] rateDiv = '0;
  logic       rateX8 = 1'b0;
  logic       wrValid = 1'b0;
  logic [7:0] wrData = '0;
  logic       statusRead = 1'b0;
  logic       hostSelect = 1'b0;
  logic       txBit, bitStrobe, readyIrq, errFlag, sdoReady;

  int vecCount = 0;
  int missCount = 0;
  bit expQ[$];

  always #2 clk = ~clk;

  txbit_serializer u0 (
    .clk(clk), .rstN(rstN), .txEnable(txEnable), .rateDiv(rateDiv),
    .rateX8(rateX8), .wrValid(wrValid), .wrData(wrData),
    .statusRead(statusRead), .hostSelect(hostSelect), .txBit(txBit),
    .bitStrobe(bitStrobe), .readyIrq(readyIrq), .errFlag(errFlag),
    .sdoReady(sdoReady)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vecCount++;
    if (!ok) begin
      missCount++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: compare each strobed bit against the scoreboard
  always @(negedge clk) begin : mon
    bit e;
    if (rstN && bitStrobe && expQ.size() > 0) begin
      e = expQ.pop_front();
      check(txBit == e, "R3 serial bit", int'(txBit), int'(e));
    end
  end

  task automatic pushByte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) expQ.push_back(b[i]);
  endtask

  task automatic hostWrite(input logic [7:0] b);
    @(negedge clk); wrValid = 1'b1; wrData = b;
    @(negedge clk); wrValid = 1'b0;
  endtask

  task automatic readStatus();
    @(negedge clk); statusRead = 1'b1;
    @(negedge clk); statusRead = 1'b0;
  endtask

  task automatic waitIrq();
    while (!readyIrq) @(negedge clk);
  endtask

  task automatic waitErr();
    while (!errFlag) @(negedge clk);
  endtask

  task automatic drain();
    while (expQ.size() > 0) @(negedge clk);
  endtask

  task automatic txOff();
    @(negedge clk); txEnable = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic txOn();
    @(negedge clk); txEnable = 1'b1;
  endtask

  task automatic measure(input logic [6:0] r, input logic cs, input int expP, input string req);
    int n;
    @(negedge clk); rateDiv = r; rateX8 = cs;
    txOn();
    while (!bitStrobe) @(negedge clk);
    @(negedge clk);
    check(!bitStrobe, "R5 strobe width", int'(bitStrobe), 0);
    n = 1;
    while (!bitStrobe) begin @(negedge clk); n++; end
    check(n == expP, req, n, expP);
    txOff();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    missCount++; vecCount++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 190000, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end

  initial begin
    hostSelect = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(txBit == 1'b0, "R1 txBit", int'(txBit), 0);
    check(bitStrobe == 1'b0, "R1 bitStrobe", int'(bitStrobe), 0);
    check(readyIrq == 1'b0, "R1 readyIrq", int'(readyIrq), 0);
    check(errFlag == 1'b0, "R1 errFlag", int'(errFlag), 0);
    check(sdoReady == 1'b0, "R1 sdoReady", int'(sdoReady), 0);

    // R1 preamble with no writes
    pushByte(8'hAA); pushByte(8'hAA);
    txOn(); drain(); txOff();
    check(errFlag == 1'b0, "R1 no error", int'(errFlag), 0);
    check(readyIrq == 1'b0, "R6 irq low when off", int'(readyIrq), 0);

    // R2 initial fill, R3 order, R6 refill handshake
    hostWrite(8'hC3); hostWrite(8'h5A);
    pushByte(8'hC3); pushByte(8'h5A); pushByte(8'h96);
    pushByte(8'h5A); pushByte(8'h81); pushByte(8'h7E);
    txOn();
    waitIrq();
    check(readyIrq == 1'b1, "R6 irq set", int'(readyIrq), 1);
    check(sdoReady == 1'b1, "R11 sdoReady mirrors", int'(sdoReady), 1);
    hostSelect = 1'b0;
    @(negedge clk);
    check(sdoReady == 1'b0, "R11 sdoReady deselected", int'(sdoReady), 0);
    hostSelect = 1'b1;
    hostWrite(8'h96);
    check(readyIrq == 1'b0, "R6 irq cleared by write", int'(readyIrq), 0);
    check(errFlag == 1'b0, "R8 no overwrite", int'(errFlag), 0);
    waitIrq();
    // R7 underrun: no refill, stale byte resent
    waitErr();
    check(errFlag == 1'b1, "R7 underrun flag", int'(errFlag), 1);
    repeat (3) @(negedge clk);
    check(errFlag == 1'b1, "R9 flag held", int'(errFlag), 1);
    readStatus();
    check(errFlag == 1'b0, "R9 flag cleared", int'(errFlag), 0);
    hostWrite(8'h81);
    waitIrq();
    // R8 overwrite of unsent data
    hostWrite(8'h24);
    check(errFlag == 1'b0, "R8 first write ok", int'(errFlag), 0);
    hostWrite(8'h7E);
    check(errFlag == 1'b1, "R8 overwrite flag", int'(errFlag), 1);
    readStatus();
    drain(); txOff();
    check(txBit == 1'b0, "R3 idle low", int'(txBit), 0);

    // R10 reinit on disable, then R2 single-write shift
    hostWrite(8'h3C);
    pushByte(8'hAA); pushByte(8'h3C);
    txOn(); drain(); txOff();
    check(errFlag == 1'b0, "R10 no error", int'(errFlag), 0);

    // R4 bit period under several settings
    measure(7'd0, 1'b0, 29, "R4 period r0");
    measure(7'd2, 1'b1, 29 * 3 * 8, "R4 period r2 x8");
    measure(7'd127, 1'b0, 29 * 128, "R4 period r127");

    check(expQ.size() == 0, "R3 scoreboard empty", expQ.size(), 0);
    $display("  == %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end
endmodule